// File: doc/BRIEF.md
# Periodic and One-Shot Interval Timer

A 32-bit interval timer driven through a 16-bit synchronous register port. An up-counter advances once per prescaler tick. In continuous mode the counter starts again from zero each time it reaches a programmable limit. In single-run mode it stops at the limit. When the count meets the limit and the interrupt is enabled, an interrupt is raised and held.

After reset the limit is all ones. Setting only the continuous-mode bit therefore gives a free-running 32-bit time base with no further setup. Software reads the count as two 16-bit halves. A read of the low half captures the high half in a shadow register, so the pair read back is consistent.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0, both count halves read 0, both limit halves read 0xFFFF, the prescaler reads 0, and `irq_o` is low.
- R2: Writing the control register at offset 0x00 with bit 0 (continuous) or bit 1 (single run) set clears the count to zero. With a prescaler of 0, the count then equals the number of clock edges since that write.
- R3: The prescaler register at offset 0x18 holds d. The count advances once every d+1 clocks.
- R4: In continuous mode (bit 0 set), a tick taken while the count equals the limit L reloads the count to zero. The counting period is therefore L+1 ticks.
- R5: In single-run mode (bit 1 set, bit 0 clear), the count stops at L. Bit 1 of the control register reads back 0 once the tick at L has been taken.
- R6: When control bit 8 is set, the tick taken at count L drives `irq_o` high. It stays high until the next write to the control register. With bit 8 clear, `irq_o` stays low.
- R7: Writing 0 to the control register stops the counter. The count then holds its value.
- R8: The limit is written as a low half at 0x08 and a high half at 0x0C. The count reads as a low half at 0x10 and a high half at 0x14. A read strobe at 0x10 copies the current high half into a shadow register, and a read of 0x14 returns that shadow.
- R9: A limit as small as 3 is honoured. In single-run mode with prescaler 0, `irq_o` is low 3 edges after the start and high 4 edges after it.
- R10: The control register reads back bits 0, 1 and 8 in place. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte offset of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (captures the shadow on a low-count read) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt, high until the next control write |

## Verification
A control write takes effect at the clock edge that samples it, and the count is zero after that edge. With prescaler d, the count then reaches floor(k/(d+1)) k edges later. The interrupt and the clearing of the single-run bit both follow the (L+1)th tick by one edge, because they come out of the same registered hit. Read data is combinational, so the bench samples it 1 ns after setting the address at a falling edge. The shadow captured by a low-half read is checked on the following cycle, one edge later. Each vector's expected values are computed from the edge count since the start write, including the edges that the read-back accesses use up.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_LIM_LO = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_LIM_HI = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_DIV    = 5'h18;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_ONCE = 1;
  localparam int unsigned BIT_IEN  = 8;

  typedef struct packed {
    logic ien;
    logic once;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned DIV_W = 16,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              once_done_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              ctrl_wr_o,
  output logic              start_o
);
  ctrl_t ctrl_q;
  logic [DIV_W-1:0] div_q;

  assign ctrl_wr_o = wr_i && (addr_i == OFS_CTRL);
  assign start_o   = ctrl_wr_o && (wdata_i[BIT_RUN] || wdata_i[BIT_ONCE]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_o) begin
      ctrl_q.run  <= wdata_i[BIT_RUN];
      ctrl_q.once <= wdata_i[BIT_ONCE];
      ctrl_q.ien  <= wdata_i[BIT_IEN];
    end else if (once_done_i) begin
      ctrl_q.once <= 1'b0;
    end
  end

  // one register per limit half, offsets 4 bytes apart
  for (genvar h = 0; h < 2; h++) begin : g_lim
    logic [BUS_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) half_q <= '1;
      else if (wr_i && (addr_i == OFS_LIM_LO + ADDR_W'(4 * h))) half_q <= wdata_i;
    end
    assign limit_o[h*BUS_W +: BUS_W] = half_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (wr_i && (addr_i == OFS_DIV)) div_q <= wdata_i[DIV_W-1:0];
  end

  assign ctrl_o = ctrl_q;
  assign div_o  = div_q;
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;
  logic             wrap;

  assign wrap   = (pre_q >= div_i);
  assign tick_o = active_i && !restart_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || !active_i || wrap) pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o   = tick_i && (cnt_q == limit_i);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (hit_o) begin
      if (periodic_i) cnt_q <= '0;   // single run holds at the limit
    end else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned DIV_W = 16,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] lim_w;
  logic [CNT_W-1:0] cnt_w;
  logic [DIV_W-1:0] div_w;
  logic             ctrl_wr_w, start_w, tick_w, hit_w, active_w;
  logic [BUS_W-1:0] shadow_q;
  logic             irq_q;

  assign active_w = ctrl_w.run || ctrl_w.once;

  itmr_regs #(.BUS_W(BUS_W), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .once_done_i (hit_w && !ctrl_w.run),
    .ctrl_o      (ctrl_w),
    .limit_o     (lim_w),
    .div_o       (div_w),
    .ctrl_wr_o   (ctrl_wr_w),
    .start_o     (start_w)
  );

  itmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni,
    .active_i  (active_w),
    .restart_i (start_w),
    .div_i     (div_w),
    .tick_o    (tick_w)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i     (tick_w),
    .restart_i  (start_w),
    .periodic_i (ctrl_w.run),
    .limit_i    (lim_w),
    .count_o    (cnt_w),
    .hit_o      (hit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               shadow_q <= '0;
    else if (rd_i && (addr_i == OFS_CNT_LO))   shadow_q <= cnt_w[CNT_W-1:BUS_W];
  end

  // control write wins over a coincident hit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  irq_q <= 1'b0;
    else if (ctrl_wr_w)           irq_q <= 1'b0;
    else if (hit_w && ctrl_w.ien) irq_q <= 1'b1;
  end
  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[BIT_RUN]  = ctrl_w.run;
        rdata_o[BIT_ONCE] = ctrl_w.once;
        rdata_o[BIT_IEN]  = ctrl_w.ien;
      end
      OFS_LIM_LO: rdata_o = lim_w[BUS_W-1:0];
      OFS_LIM_HI: rdata_o = lim_w[CNT_W-1:BUS_W];
      OFS_CNT_LO: rdata_o = cnt_w[BUS_W-1:0];
      OFS_CNT_HI: rdata_o = shadow_q;
      OFS_DIV:    rdata_o = BUS_W'(div_w);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  lim,
  input logic              run,
  input logic              once,
  input logic              ien
);
  logic cw;
  assign cw = wr_i && (addr_i == OFS_CTRL);

  // R6
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw |=> !irq_o);

  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ien));

  // R7
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !once && !cw) |=> $stable(cnt));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((run || once) && !cw) |=> (cnt == $past(cnt) + 1'b1 || $stable(cnt) || cnt == '0));

  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !cw && cnt == lim) |=> (cnt == '0 || $stable(cnt)));

  // R5
  once_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(once) && !run && !$past(cw)) |-> cnt == lim);
endmodule

bind interval_timer itmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .irq_o  (irq_o),
  .cnt    (cnt_w),
  .lim    (lim_w),
  .run    (ctrl_w.run),
  .once   (ctrl_w.once),
  .ien    (ctrl_w.ien)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  interval_timer u_interval_timer (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .irq_o
  );

  typedef struct packed {
    logic [15:0] div;
    logic [31:0] lim;
    logic        once;
    logic        ien;
    logic [15:0] k;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd0, 32'd100,  1'b0, 1'b1, 16'd37},
    '{16'd0, 32'd9,    1'b0, 1'b1, 16'd25},
    '{16'd8, 32'd1000, 1'b0, 1'b0, 16'd50},
    '{16'd2, 32'd4,    1'b1, 1'b1, 16'd30},
    '{16'd0, 32'd3,    1'b1, 1'b1, 16'd3},
    '{16'd0, 32'd3,    1'b1, 1'b1, 16'd4},
    '{16'd0, 32'd3,    1'b1, 1'b0, 16'd10},
    '{16'd0, 32'd5,    1'b0, 1'b0, 16'd12}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    vec_t v;
    int t, t2, ecnt, L;
    logic eirq, edone;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(5'h00, d); chk("R1 ctrl", d, 0);
    rd(5'h08, d); chk("R1 lim_lo", d, 16'hFFFF);
    rd(5'h0C, d); chk("R1 lim_hi", d, 16'hFFFF);
    rd(5'h18, d); chk("R1 div", d, 0);
    rd(5'h10, d); chk("R1 cnt_lo", d, 0);
    rd(5'h14, d); chk("R1 cnt_hi", d, 0);
    chk("R1 irq", irq_o, 0);
    rd(5'h04, d); chk("R10 unmapped", d, 0);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      L = int'(v.lim);
      wr(5'h00, 16'h0000);
      wr(5'h18, v.div);
      wr(5'h08, v.lim[15:0]);
      wr(5'h0C, v.lim[31:16]);
      wr(5'h00, {7'b0, v.ien, 6'b0, v.once, ~v.once});
      idle(int'(v.k));
      t  = int'(v.k) / (int'(v.div) + 1);
      t2 = (int'(v.k) + 2) / (int'(v.div) + 1);
      if (v.once) ecnt = (t > L) ? L : t;
      else        ecnt = t % (L + 1);
      eirq  = v.ien && (t >= L + 1);
      edone = (t2 >= L + 1);
      #1 chk($sformatf("R6 irq vec%0d", i), irq_o, eirq);
      rd(5'h10, d); chk($sformatf("R2/R3/R4/R5 cnt vec%0d", i), d, ecnt);
      rd(5'h14, d); chk($sformatf("R8 cnt_hi vec%0d", i), d, 0);
      rd(5'h00, d);
      chk($sformatf("R5/R10 ctrl vec%0d", i), d,
          {7'b0, v.ien, 6'b0, v.once && !edone, ~v.once});
    end

    // R6 irq held, then cleared by a control write
    wr(5'h00, 16'h0000);
    wr(5'h18, 16'd0);
    wr(5'h08, 16'd3);
    wr(5'h0C, 16'd0);
    wr(5'h00, 16'h0101);
    idle(10);
    #1 chk("R6 irq held", irq_o, 1);
    wr(5'h00, 16'h0100);
    #1 chk("R6 irq cleared", irq_o, 0);

    // R7 stop holds count (tick at the stopping edge still lands)
    wr(5'h08, 16'hFFFF);
    wr(5'h0C, 16'hFFFF);
    wr(5'h00, 16'h0001);
    idle(20);
    wr(5'h00, 16'h0000);
    idle(10);
    rd(5'h10, d); chk("R7 stopped cnt", d, 21);
    idle(5);
    rd(5'h10, d); chk("R7 still held", d, 21);

    // R2 restart clears count
    wr(5'h00, 16'h0001);
    idle(5);
    rd(5'h10, d); chk("R2 restart", d, 5);

    // R8 shadow across the 16-bit carry, free-running time base
    wr(5'h00, 16'h0001);
    idle(65535);
    rd(5'h10, d); chk("R8 lo before carry", d, 16'hFFFF);
    rd(5'h14, d); chk("R8 hi from shadow", d, 16'h0000);
    rd(5'h10, d); chk("R8 lo after carry", d, 16'h0001);
    rd(5'h14, d); chk("R8 hi after carry", d, 16'h0001);
    rd(5'h08, d); chk("R8 lim_lo", d, 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule